// File: doc/BRIEF.md
# Iterative Integer Divider

A sequential divider that turns a 32-bit or 16-bit dividend and a 16-bit divisor into a 16-bit quotient and a 16-bit remainder. Two select inputs choose among four operating modes: unsigned or two's-complement, and a full 32-bit dividend or one taken from the low half of the dividend bus. Every mode uses the same shift-and-subtract loop, which settles one quotient bit per clock, so every division takes the same number of cycles.

A caller drives the operands with a one-cycle start pulse while the block is idle. It then waits for the one-cycle done pulse and reads the quotient, remainder and two exception flags. These hold until the next accepted start. Signed operands are turned into magnitudes before the loop, and the signs are put back afterwards. A zero divisor and a quotient that does not fit in 16 bits are both reported, and each gives a fixed result pattern.

Top module: `int_divider`

## Requirements
- R1: `wide_i`=1 divides the full 32-bit `dividend_i`, whose high word is bits [31:16]. `wide_i`=0 divides only `dividend_i[15:0]`. `signed_i`=1 treats the operands as two's complement and `signed_i`=0 treats them as unsigned.
- R2: When `wide_i`=0, `dividend_i[31:16]` has no effect. The low word is zero-extended (unsigned) or sign-extended (signed) to 32 bits.
- R3: In unsigned mode with no exception, `quotient_o` is floor(dividend/divisor) and `remainder_o` is dividend - quotient*divisor.
- R4: In signed mode with no exception, the quotient is truncated toward zero, it is negative exactly when the operand signs differ, and the remainder carries the sign of the dividend (or is zero).
- R5: The done pulse follows the accepting clock edge by exactly 16 clock edges in all four modes, and `busy_o` is high for those 16 cycles.
- R6: `done_o` is high for exactly one cycle. Results and flags stay stable from done until the next accepted start.
- R7: A start pulse that arrives while `busy_o`=1 is ignored. It changes neither the latency nor the result.
- R8: A zero divisor sets `dz_o`=1 and clears `ovf_o`, returns `quotient_o`=16'hFFFF, and returns `remainder_o`=`dividend_i[15:0]` as captured at start.
- R9: A nonzero divisor whose true quotient falls outside the 16-bit range (0..65535 unsigned, -32768..32767 signed) sets `ovf_o`=1 and clears `dz_o`. It returns the same 16'hFFFF / low-word pattern as R8.
- R10: After reset, `busy_o`, `done_o`, `quotient_o`, `remainder_o`, `ovf_o` and `dz_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a division when idle |
| wide_i | input | 1 | 1: 32-bit dividend, 0: 16-bit dividend |
| signed_i | input | 1 | 1: two's-complement operands |
| dividend_i | input | 32 | Dividend, high word in [31:16] |
| divisor_i | input | 16 | Divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | 16 | Quotient |
| remainder_o | output | 16 | Remainder |
| ovf_o | output | 1 | Quotient out of range |
| dz_o | output | 1 | Divisor was zero |

## Verification
The assertions assume that `start_i` is a clean synchronous level and that the caller reads results only while done is high or while the block is idle with no start pending. The stimulus drives every input on the falling edge and lowers start after one cycle. The only start pulses that land while busy are the deliberate ones in the ignore test. The remainder bound and the zero-divisor check compare against operands that the checker captures on the accepting edge. The bench can therefore change the operand buses freely once a division is under way, and it does so on purpose.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef struct packed {
    logic sgn;     // signed mode
    logic neg_q;   // negate quotient
    logic neg_r;   // negate remainder
    logic hi_big;  // high part >= divisor: quotient needs more than W bits
    logic dz;      // divisor zero
  } div_ctl_t;
endpackage

// File: rtl/div_prep.sv
module div_prep
  import div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2*W-1:0] dividend_i,
  input  logic [W-1:0]   divisor_i,
  input  logic           wide_i,
  input  logic           signed_i,
  output logic [W-1:0]   mag_hi_o,
  output logic [W-1:0]   mag_lo_o,
  output logic [W-1:0]   mag_dvs_o,
  output div_ctl_t       ctl_o
);
  logic [2*W-1:0] ext, mag_dnd;
  logic           dnd_neg, dvs_neg;

  always_comb begin
    if (wide_i) ext = dividend_i;
    else        ext = {{W{signed_i & dividend_i[W-1]}}, dividend_i[W-1:0]};
    dnd_neg   = signed_i & ext[2*W-1];
    dvs_neg   = signed_i & divisor_i[W-1];
    mag_dnd   = dnd_neg ? (~ext + 1'b1) : ext;
    mag_dvs_o = dvs_neg ? (~divisor_i + 1'b1) : divisor_i;
    mag_hi_o  = mag_dnd[2*W-1:W];
    mag_lo_o  = mag_dnd[W-1:0];
    ctl_o.sgn    = signed_i;
    ctl_o.neg_q  = dnd_neg ^ dvs_neg;
    ctl_o.neg_r  = dnd_neg;
    ctl_o.dz     = (divisor_i == '0);
    ctl_o.hi_big = (mag_dnd[2*W-1:W] >= mag_dvs_o);
  end
endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] init_hi_i,
  input  logic [W-1:0] init_lo_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o,
  output logic         busy_o,
  output logic         done_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  logic [W:0]    sh;
  logic [W+1:0]  diff;
  logic          borrow;

  // restoring step: shift in next dividend bit, trial subtract
  always_comb begin
    sh     = {rem_q, quo_q[W-1]};
    diff   = {1'b0, sh} - {2'b0, dvs_q};
    borrow = diff[W+1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        rem_q  <= init_hi_i;
        quo_q  <= init_lo_i;
        dvs_q  <= dvs_i;
        cnt_q  <= CW'(W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= borrow ? sh[W-1:0] : diff[W-1:0];
        quo_q <= {quo_q[W-2:0], ~borrow};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign rem_o  = rem_q;
  assign quo_o  = quo_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/div_post.sv
module div_post
  import div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] lo_word_i,
  input  div_ctl_t     ctl_i,
  output logic [W-1:0] quotient_o,
  output logic [W-1:0] remainder_o,
  output logic         ovf_o,
  output logic         dz_o
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN_MAG = {1'b1, {(W-1){1'b0}}};

  logic range_ovf;

  always_comb begin
    range_ovf = ctl_i.sgn & (ctl_i.neg_q ? (quo_i > SMIN_MAG) : (quo_i > SMAX));
    dz_o      = ctl_i.dz;
    ovf_o     = ~ctl_i.dz & (ctl_i.hi_big | range_ovf);
    if (ctl_i.dz || ovf_o) begin
      quotient_o  = '1;
      remainder_o = lo_word_i;
    end else begin
      quotient_o  = ctl_i.neg_q ? (~quo_i + 1'b1) : quo_i;
      remainder_o = ctl_i.neg_r ? (~rem_i + 1'b1) : rem_i;
    end
  end
endmodule

// File: rtl/int_divider.sv
module int_divider
  import div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           wide_i,
  input  logic           signed_i,
  input  logic [2*W-1:0] dividend_i,
  input  logic [W-1:0]   divisor_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [W-1:0]   quotient_o,
  output logic [W-1:0]   remainder_o,
  output logic           ovf_o,
  output logic           dz_o
);
  logic [W-1:0] mag_hi, mag_lo, mag_dvs, rem, quo, lo_q;
  div_ctl_t     ctl_d, ctl_q;
  logic         accept;

  assign accept = start_i & ~busy_o;

  div_prep #(.W(W)) i_prep (
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .wide_i     (wide_i),
    .signed_i   (signed_i),
    .mag_hi_o   (mag_hi),
    .mag_lo_o   (mag_lo),
    .mag_dvs_o  (mag_dvs),
    .ctl_o      (ctl_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      lo_q  <= '0;
    end else if (accept) begin
      ctl_q <= ctl_d;
      lo_q  <= dividend_i[W-1:0];
    end
  end

  div_core #(.W(W)) i_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .init_hi_i (mag_hi),
    .init_lo_i (mag_lo),
    .dvs_i     (mag_dvs),
    .rem_o     (rem),
    .quo_o     (quo),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  div_post #(.W(W)) i_post (
    .quo_i       (quo),
    .rem_i       (rem),
    .lo_word_i   (lo_q),
    .ctl_i       (ctl_q),
    .quotient_o  (quotient_o),
    .remainder_o (remainder_o),
    .ovf_o       (ovf_o),
    .dz_o        (dz_o)
  );
endmodule

// File: rtl/div_checker.sv
module div_checker #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         signed_i,
  input logic [W-1:0] divisor_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] quotient_o,
  input logic [W-1:0] remainder_o,
  input logic         ovf_o,
  input logic         dz_o
);
  localparam int CW = $clog2(W + 2);

  logic [CW-1:0] lat_q;
  logic [W-1:0]  dvs_q;
  logic          sgn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      dvs_q <= '0;
      sgn_q <= 1'b0;
    end else if (start_i && !busy_o) begin
      lat_q <= '0;
      dvs_q <= divisor_i;
      sgn_q <= signed_i;
    end else if (busy_o) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> lat_q == CW'(W)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R5
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o) && !$past(start_i)) |-> ($stable(quotient_o) && $stable(remainder_o))); // R6
  AST_BUSY_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && lat_q < CW'(W-1)) |=> busy_o); // R7
  AST_ZERO_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && dvs_q == '0) |-> (dz_o && !ovf_o && quotient_o == '1)); // R8
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(dz_o && ovf_o)); // R9
  AST_UREM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !sgn_q && !ovf_o && !dz_o) |-> remainder_o < dvs_q); // R3
endmodule

bind int_divider div_checker #(.W(W)) i_div_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .signed_i    (signed_i),
  .divisor_i   (divisor_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .quotient_o  (quotient_o),
  .remainder_o (remainder_o),
  .ovf_o       (ovf_o),
  .dz_o        (dz_o)
);

// File: tb/test_int_divider.sv
module test_int_divider;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        wide_i = 1'b0;
  logic        signed_i = 1'b0;
  logic [31:0] dividend_i = '0;
  logic [15:0] divisor_i = '0;
  logic        busy_o, done_o, ovf_o, dz_o;
  logic [15:0] quotient_o, remainder_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  int_divider i_int_divider (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .wide_i(wide_i),
    .signed_i(signed_i), .dividend_i(dividend_i), .divisor_i(divisor_i),
    .busy_o(busy_o), .done_o(done_o), .quotient_o(quotient_o),
    .remainder_o(remainder_o), .ovf_o(ovf_o), .dz_o(dz_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] dnd, input logic [15:0] dvs,
                                input logic wide, input logic sgn,
                                output logic [15:0] q, output logic [15:0] r,
                                output logic ovf, output logic dz);
    logic [31:0] ext;
    longint a, b, qq, rr;
    ext = wide ? dnd : (sgn ? {{16{dnd[15]}}, dnd[15:0]} : {16'h0, dnd[15:0]});
    dz = 1'b0; ovf = 1'b0;
    if (dvs == 16'h0) begin
      dz = 1'b1; q = 16'hFFFF; r = dnd[15:0];
      return;
    end
    if (sgn) begin
      a = longint'($signed(ext)); b = longint'($signed(dvs));
    end else begin
      a = longint'({32'h0, ext}); b = longint'({48'h0, dvs});
    end
    qq = a / b; rr = a % b;
    ovf = sgn ? (qq > 32767 || qq < -32768) : (qq > 65535);
    if (ovf) begin q = 16'hFFFF; r = dnd[15:0]; end
    else begin q = qq[15:0]; r = rr[15:0]; end
  endfunction

  // one division; poke=1 fires a second start while busy (R7)
  task automatic run_div(input logic [31:0] dnd, input logic [15:0] dvs,
                         input logic wide, input logic sgn, input string req,
                         input bit poke);
    logic [15:0] eq, er, q0, r0;
    logic eo, ez;
    int n;
    model(dnd, dvs, wide, sgn, eq, er, eo, ez);
    @(negedge clk_i);
    dividend_i = dnd; divisor_i = dvs; wide_i = wide; signed_i = sgn; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R5", "busy after start", busy_o, 1);
    if (poke) begin
      start_i = 1'b1; dividend_i = ~dnd; divisor_i = dvs + 16'd3; signed_i = ~sgn;
    end
    n = 1;
    while (done_o !== 1'b1 && n < 40) begin
      @(negedge clk_i);
      start_i = 1'b0;
      n++;
    end
    chk(n - 1 == 16, "R5", "latency", n - 1, 16);
    chk(busy_o === 1'b0, "R5", "busy at done", busy_o, 0);
    chk(quotient_o === eq, req, "quotient", quotient_o, eq);
    chk(remainder_o === er, req, "remainder", remainder_o, er);
    chk(ovf_o === eo, req, "ovf", ovf_o, eo);
    chk(dz_o === ez, req, "dz", dz_o, ez);
    q0 = quotient_o; r0 = remainder_o;
    dividend_i = 32'h5A5A_A5A5; divisor_i = 16'h0101;
    @(negedge clk_i);
    chk(done_o === 1'b0, "R6", "done pulse width", done_o, 0);
    @(negedge clk_i);
    chk(quotient_o === q0 && remainder_o === r0, "R6", "hold while idle",
        {quotient_o, remainder_o}, {q0, r0});
  endtask

  task automatic t_reset();
    chk(busy_o === 1'b0 && done_o === 1'b0, "R10", "busy/done at reset", {busy_o, done_o}, 0);
    chk(quotient_o === 16'h0 && remainder_o === 16'h0, "R10", "results at reset",
        {quotient_o, remainder_o}, 0);
    chk(ovf_o === 1'b0 && dz_o === 1'b0, "R10", "flags at reset", {ovf_o, dz_o}, 0);
  endtask

  task automatic t_unsigned();
    run_div(32'h0000_03E8, 16'd7, 1'b0, 1'b0, "R3", 0);
    run_div(32'h0012_3456, 16'h1234, 1'b1, 1'b0, "R3", 0);
    run_div(32'hFFFE_FFFF, 16'hFFFF, 1'b1, 1'b0, "R3", 0);
    run_div(32'h0000_FFFF, 16'd1, 1'b0, 1'b0, "R1", 0);
  endtask

  task automatic t_signed();
    run_div(32'h0000_FFF9, 16'd2, 1'b0, 1'b1, "R4", 0);        // -7/2
    run_div(32'h0000_0007, 16'hFFFE, 1'b0, 1'b1, "R4", 0);     // 7/-2
    run_div(32'hFFFE_7960, 16'd300, 1'b1, 1'b1, "R4", 0);      // -100000/300
    run_div(32'h4000_0000, 16'h8000, 1'b1, 1'b1, "R4", 0);     // -> -32768
  endtask

  task automatic t_extend();
    run_div(32'hBEEF_8000, 16'd16, 1'b0, 1'b1, "R2", 0);
    run_div(32'hBEEF_8000, 16'd16, 1'b0, 1'b0, "R2", 0);
  endtask

  task automatic t_overflow();
    run_div(32'h0001_0000, 16'd1, 1'b1, 1'b0, "R9", 0);
    run_div(32'h0000_8000, 16'hFFFF, 1'b0, 1'b1, "R9", 0);     // -32768/-1
    run_div(32'hC000_0000, 16'h8000, 1'b1, 1'b1, "R9", 0);     // 32768
  endtask

  task automatic t_zero();
    run_div(32'h1234_ABCD, 16'h0, 1'b1, 1'b0, "R8", 0);
    run_div(32'h0000_8001, 16'h0, 1'b0, 1'b1, "R8", 0);
  endtask

  task automatic t_ignore_start();
    run_div(32'h0000_1F40, 16'd9, 1'b1, 1'b0, "R7", 1);
    run_div(32'hFFFF_FC18, 16'd7, 1'b1, 1'b1, "R7", 1);
  endtask

  task automatic t_sweep();
    logic [31:0] lf = 32'hACE1_2468;
    for (int i = 0; i < 40; i++) begin
      logic [31:0] d;
      logic [15:0] v;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      d = (i % 3 == 0) ? {8'h0, lf[23:0]} : lf;
      v = lf[15:0] ^ lf[31:16];
      run_div(d, v, i[1], i[0], i[0] ? "R4" : "R3", 0);
    end
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_unsigned();
    t_signed();
    t_extend();
    t_overflow();
    t_zero();
    t_ignore_start();
    t_sweep();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule